// File: doc/BRIEF.md
# Boot Record Message Decoder

This block sits between a serial boot-memory reader and the on-chip register and program memories. It takes the raw byte stream read from the boot memory, starting at address 0, and turns it into single-byte write requests on an internal bus. The stream is a sequence of typed messages. A write message has a header and then a payload. The header holds a length, a chip address and a target subaddress. Each payload byte leaves the block as one write request. It is tagged with the chip address, the base subaddress, its offset inside the message, and a flag on the final byte. Single padding bytes may sit between messages and are skipped.

The block also keeps a port-write enable flag. A write message to the local chip's core control register sets or clears this flag. Payload aimed at the local interface register block is only forwarded while the flag is set. Parsing stops for good when the stream holds an unknown type byte or when the reader signals end of data. A done output then rises, with an error output that says whether the stop was clean.

Top module: `boot_msg_parser`

## Requirements
- R1: After reset, `in_ready` is 1, and `wr_valid`, `wr_last`, `done`, `error` and `iface_en` are all 0.
- R2: A type byte of 0x03 seen between messages is consumed. It produces no write request and leaves the parser waiting for the next type byte.
- R3: A type byte of 0x01 starts a write message. Its next five bytes are the length (high byte first), the chip address, and the subaddress (high byte first). These appear on `wr_chip` and `wr_addr` for every payload byte of the message.
- R4: A message with length L carries L-3 payload bytes. Each one is output once, in order, on `wr_data` with `wr_idx` counting 0, 1, 2 and so on. `wr_last` is 1 only on the byte with offset L-4.
- R5: A length of exactly 3 carries no payload. The byte that follows the subaddress is taken as a new type byte.
- R6: A length below 3 stops parsing: `done` and `error` go to 1.
- R7: A type byte other than 0x01 or 0x03 stops parsing: `done` and `error` go to 1 and `in_ready` drops to 0. Both flags hold until reset.
- R8: `in_end` high while `in_valid` is low stops parsing. `error` is 0 if this happens between messages and 1 if it happens inside a message.
- R9: A payload byte with offset 1, chip 0x00 and subaddress 0x081C sets `iface_en` to bit 6 of that byte.
- R10: Payload bytes with chip 0x00 and subaddress 0x0800 are consumed but not output while `iface_en` is 0.
- R11: A payload byte accepted at a clock edge is presented with `wr_valid` high for exactly the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_end | input | 1 | Reader has no more bytes |
| in_ready | output | 1 | Byte is taken at this edge when in_valid is high |
| wr_valid | output | 1 | Write request present |
| wr_chip | output | 8 | Chip address of the request |
| wr_addr | output | 16 | Base subaddress of the message |
| wr_idx | output | 16 | Offset of the byte within the payload |
| wr_data | output | 8 | Payload byte |
| wr_last | output | 1 | Final payload byte of the message |
| iface_en | output | 1 | Port-write enable flag |
| done | output | 1 | Parsing has stopped |
| error | output | 1 | Stop was caused by a bad stream |

## Verification
Every result is due one clock edge after the byte or `in_end` that causes it. This covers a write request, the `iface_en` update, and the `done`, `error` and `in_ready` changes. The bench drives each byte at a falling edge and lets the next rising edge take it. It reads all outputs at the falling edge that follows, so each expectation is compared in the single cycle where it must be visible. A dropped write is checked in that same cycle, by seeing `wr_valid` low.

// File: rtl/boot_msg_pkg.sv
// Shared constants and parser state encoding for the boot record decoder.
package boot_msg_pkg;
    localparam logic [7:0]  TYPE_WRITE = 8'h01;
    localparam logic [7:0]  TYPE_NOP   = 8'h03;
    localparam logic [15:0] HDR_BYTES  = 16'd3;

    typedef enum logic [2:0] {
        ST_TYPE,
        ST_LEN_H,
        ST_LEN_L,
        ST_CHIP,
        ST_ADR_H,
        ST_ADR_L,
        ST_DATA,
        ST_HALT
    } parse_st_t;
endpackage

// File: rtl/boot_msg_fsm.sv
// Header parser: walks type, length, chip and subaddress bytes and emits one
// combinational beat per payload byte.
// Assumes the input stream has no backpressure beyond in_ready, which falls only
// once parsing has stopped.
module boot_msg_fsm
    import boot_msg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_end,
    output logic        in_ready,
    output logic        beat,
    output logic [7:0]  beat_chip,
    output logic [15:0] beat_addr,
    output logic [15:0] beat_idx,
    output logic [7:0]  beat_data,
    output logic        beat_last,
    output logic        done,
    output logic        error
);
    parse_st_t   st;
    logic [7:0]  len_hi;
    logic [15:0] rem;
    logic [15:0] idx;
    logic [7:0]  chip;
    logic [15:0] addr;
    logic        accept;
    logic [15:0] len_full;

    // Handshake and payload beat decode
    always_comb begin
        in_ready  = !done;
        accept    = in_valid && in_ready;
        len_full  = {len_hi, in_data};
        beat      = accept && (st == ST_DATA);
        beat_chip = chip;
        beat_addr = addr;
        beat_idx  = idx;
        beat_data = in_data;
        beat_last = (rem == 16'd1);
    end

    // Parser state, header fields and payload counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_TYPE;
            len_hi <= '0;
            rem    <= '0;
            idx    <= '0;
            chip   <= '0;
            addr   <= '0;
            done   <= 1'b0;
            error  <= 1'b0;
        end else if (accept) begin
            case (st)
                ST_TYPE: begin
                    if (in_data == TYPE_WRITE) begin
                        st <= ST_LEN_H;
                    end else if (in_data != TYPE_NOP) begin
                        done  <= 1'b1;
                        error <= 1'b1;
                        st    <= ST_HALT;
                    end
                end
                ST_LEN_H: begin
                    len_hi <= in_data;
                    st     <= ST_LEN_L;
                end
                ST_LEN_L: begin
                    if (len_full < HDR_BYTES) begin
                        done  <= 1'b1;
                        error <= 1'b1;
                        st    <= ST_HALT;
                    end else begin
                        rem <= len_full - HDR_BYTES;
                        st  <= ST_CHIP;
                    end
                end
                ST_CHIP: begin
                    chip <= in_data;
                    st   <= ST_ADR_H;
                end
                ST_ADR_H: begin
                    addr[15:8] <= in_data;
                    st         <= ST_ADR_L;
                end
                ST_ADR_L: begin
                    addr[7:0] <= in_data;
                    idx       <= '0;
                    st        <= (rem == 16'd0) ? ST_TYPE : ST_DATA;
                end
                ST_DATA: begin
                    idx <= idx + 16'd1;
                    rem <= rem - 16'd1;
                    if (rem == 16'd1) st <= ST_TYPE;
                end
                default: ;
            endcase
        end else if (in_end && !in_valid && !done) begin
            done  <= 1'b1;
            error <= (st != ST_TYPE);
            st    <= ST_HALT;
        end
    end
endmodule

// File: rtl/boot_msg_gate.sv
// Output stage: tracks the port-write enable flag from control register writes,
// drops interface register writes while it is clear, and registers the request.
// Assumes each payload beat lasts one cycle.
module boot_msg_gate #(
    parameter logic [7:0]  LOCAL_CHIP = 8'h00,
    parameter logic [15:0] CTRL_ADDR  = 16'h081C,
    parameter logic [15:0] IFACE_ADDR = 16'h0800,
    parameter int          EN_BYTE    = 1,
    parameter int          EN_BIT     = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        beat,
    input  logic [7:0]  beat_chip,
    input  logic [15:0] beat_addr,
    input  logic [15:0] beat_idx,
    input  logic [7:0]  beat_data,
    input  logic        beat_last,
    output logic        wr_valid,
    output logic [7:0]  wr_chip,
    output logic [15:0] wr_addr,
    output logic [15:0] wr_idx,
    output logic [7:0]  wr_data,
    output logic        wr_last,
    output logic        iface_en
);
    localparam logic [15:0] EN_IDX = 16'(EN_BYTE);

    logic local_hit;
    logic ctrl_hit;
    logic iface_hit;
    logic pass;

    // Target classification of the current beat
    always_comb begin
        local_hit = (beat_chip == LOCAL_CHIP);
        ctrl_hit  = local_hit && (beat_addr == CTRL_ADDR) && (beat_idx == EN_IDX);
        iface_hit = local_hit && (beat_addr == IFACE_ADDR);
        pass      = beat && (!iface_hit || iface_en);
    end

    // Enable flag update from the control register byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iface_en <= 1'b0;
        end else if (beat && ctrl_hit) begin
            iface_en <= beat_data[EN_BIT];
        end
    end

    // Registered write request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_chip  <= '0;
            wr_addr  <= '0;
            wr_idx   <= '0;
            wr_data  <= '0;
            wr_last  <= 1'b0;
        end else begin
            wr_valid <= pass;
            wr_last  <= pass && beat_last;
            if (pass) begin
                wr_chip <= beat_chip;
                wr_addr <= beat_addr;
                wr_idx  <= beat_idx;
                wr_data <= beat_data;
            end
        end
    end
endmodule

// File: rtl/boot_msg_parser.sv
// Top: decodes a boot record byte stream into gated single-byte write requests.
// Assumes a reader that presents bytes in memory order from address 0.
module boot_msg_parser #(
    parameter logic [7:0]  LOCAL_CHIP = 8'h00,
    parameter logic [15:0] CTRL_ADDR  = 16'h081C,
    parameter logic [15:0] IFACE_ADDR = 16'h0800,
    parameter int          EN_BYTE    = 1,
    parameter int          EN_BIT     = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_end,
    output logic        in_ready,
    output logic        wr_valid,
    output logic [7:0]  wr_chip,
    output logic [15:0] wr_addr,
    output logic [15:0] wr_idx,
    output logic [7:0]  wr_data,
    output logic        wr_last,
    output logic        iface_en,
    output logic        done,
    output logic        error
);
    logic        beat;
    logic [7:0]  beat_chip;
    logic [15:0] beat_addr;
    logic [15:0] beat_idx;
    logic [7:0]  beat_data;
    logic        beat_last;

    boot_msg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_end    (in_end),
        .in_ready  (in_ready),
        .beat      (beat),
        .beat_chip (beat_chip),
        .beat_addr (beat_addr),
        .beat_idx  (beat_idx),
        .beat_data (beat_data),
        .beat_last (beat_last),
        .done      (done),
        .error     (error)
    );

    boot_msg_gate #(
        .LOCAL_CHIP (LOCAL_CHIP),
        .CTRL_ADDR  (CTRL_ADDR),
        .IFACE_ADDR (IFACE_ADDR),
        .EN_BYTE    (EN_BYTE),
        .EN_BIT     (EN_BIT)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (beat),
        .beat_chip (beat_chip),
        .beat_addr (beat_addr),
        .beat_idx  (beat_idx),
        .beat_data (beat_data),
        .beat_last (beat_last),
        .wr_valid  (wr_valid),
        .wr_chip   (wr_chip),
        .wr_addr   (wr_addr),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .wr_last   (wr_last),
        .iface_en  (iface_en)
    );
endmodule

// File: rtl/boot_msg_parser_chk.sv
// Temporal checks on the boot record decoder ports, bound to the top.
module boot_msg_parser_chk #(
    parameter logic [7:0]  LOCAL_CHIP = 8'h00,
    parameter logic [15:0] IFACE_ADDR = 16'h0800
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        wr_valid,
    input logic [7:0]  wr_chip,
    input logic [15:0] wr_addr,
    input logic        wr_last,
    input logic        iface_en,
    input logic        done,
    input logic        error
);
    // R11
    wr_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(in_valid && in_ready));

    // R4
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_last |-> wr_valid);

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && ($stable(error)));

    // R7
    halt_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    // R6
    error_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R10
    iface_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_chip == LOCAL_CHIP && wr_addr == IFACE_ADDR) |-> $past(iface_en));
endmodule

bind boot_msg_parser boot_msg_parser_chk #(
    .LOCAL_CHIP (LOCAL_CHIP),
    .IFACE_ADDR (IFACE_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .wr_valid (wr_valid),
    .wr_chip  (wr_chip),
    .wr_addr  (wr_addr),
    .wr_last  (wr_last),
    .iface_en (iface_en),
    .done     (done),
    .error    (error)
);

// File: tb/boot_msg_parser_tb.sv
`timescale 1ns/1ps
module boot_msg_parser_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_end = 1'b0;
    logic        in_ready;
    logic        wr_valid;
    logic [7:0]  wr_chip;
    logic [15:0] wr_addr;
    logic [15:0] wr_idx;
    logic [7:0]  wr_data;
    logic        wr_last;
    logic        iface_en;
    logic        done;
    logic        error;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    boot_msg_parser u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_end(in_end), .in_ready(in_ready), .wr_valid(wr_valid),
        .wr_chip(wr_chip), .wr_addr(wr_addr), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_last(wr_last), .iface_en(iface_en),
        .done(done), .error(error)
    );

    // Row: byte, expect valid, chip, subaddress, offset, last
    localparam int NV = 39;
    localparam logic [41:0] VEC [NV] = '{
        {8'h03, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h01, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h05, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h08, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h1C, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b1, 8'h00, 16'h081C, 8'd0, 1'b0},
        {8'h40, 1'b1, 8'h00, 16'h081C, 8'd1, 1'b1},
        {8'h03, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h03, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h01, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h05, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h08, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'hAA, 1'b1, 8'h00, 16'h0800, 8'd0, 1'b0},
        {8'h55, 1'b1, 8'h00, 16'h0800, 8'd1, 1'b1},
        {8'h01, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h03, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h04, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h01, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h04, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h04, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h77, 1'b1, 8'h00, 16'h0400, 8'd0, 1'b1},
        {8'h01, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h00, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h04, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h05, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h12, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h34, 1'b0, 8'h00, 16'h0000, 8'd0, 1'b0},
        {8'h99, 1'b1, 8'h05, 16'h1234, 8'd0, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Drive one byte at a falling edge; return at the next falling edge
    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic put_list(input logic [7:0] b [], input int n);
        for (int i = 0; i < n; i++) put(b[i]);
    endtask

    task automatic end_pulse();
        in_end = 1'b1;
        @(posedge clk);
        #1;
        in_end = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        summary();
    end

    initial begin
        logic [7:0] seq [];
        do_reset();
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(wr_valid == 1'b0 && wr_last == 1'b0, "R1 wr_valid", wr_valid, 0);
        chk(done == 1'b0 && error == 1'b0, "R1 done", done, 0);
        chk(iface_en == 1'b0, "R1 iface_en", iface_en, 0);

        // R10 interface write dropped before the enable is set
        seq = '{8'h01, 8'h00, 8'h04, 8'h00, 8'h08, 8'h00};
        put_list(seq, 6);
        put(8'h11);
        chk(wr_valid == 1'b0, "R10 gated write", wr_valid, 0);

        // Table walk: R2 R3 R4 R5 R9 R11
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  b;
            logic        ev;
            logic [7:0]  ec;
            logic [15:0] ea;
            logic [7:0]  ei;
            logic        el;
            {b, ev, ec, ea, ei, el} = VEC[i];
            put(b);
            chk(wr_valid == ev, $sformatf("R11/R2/R5 valid row %0d", i), wr_valid, ev);
            if (ev) begin
                chk(wr_chip == ec && wr_addr == ea,
                    $sformatf("R3 target row %0d", i), {wr_chip, wr_addr}, {ec, ea});
                chk(wr_idx == 16'(ei) && wr_data == b,
                    $sformatf("R4 offset/data row %0d", i), {wr_idx, wr_data}, {8'h00, ei, b});
            end
            chk(wr_last == el, $sformatf("R4 last row %0d", i), wr_last, el);
        end
        chk(iface_en == 1'b1, "R9 enable set", iface_en, 1);

        // R9 clear the enable, then R10 drop again
        seq = '{8'h01, 8'h00, 8'h05, 8'h00, 8'h08, 8'h1C, 8'hFF, 8'hBF};
        put_list(seq, 8);
        chk(iface_en == 1'b0, "R9 enable cleared", iface_en, 0);
        seq = '{8'h01, 8'h00, 8'h04, 8'h00, 8'h08, 8'h00};
        put_list(seq, 6);
        put(8'h22);
        chk(wr_valid == 1'b0, "R10 gated after clear", wr_valid, 0);

        // R8 clean end between messages
        end_pulse();
        chk(done == 1'b1 && error == 1'b0, "R8 clean end", {done, error}, 2);
        chk(in_ready == 1'b0, "R8 ready after end", in_ready, 0);

        // R1 reset clears flag and status
        do_reset();
        chk(done == 1'b0 && iface_en == 1'b0 && in_ready == 1'b1, "R1 after rerun",
            {done, iface_en, in_ready}, 1);

        // R2 padding alone leaves parser running
        put(8'h03);
        put(8'h03);
        chk(done == 1'b0 && wr_valid == 1'b0, "R2 padding", {done, wr_valid}, 0);

        // R7 unknown type byte
        put(8'h07);
        chk(done == 1'b1 && error == 1'b1, "R7 bad type", {done, error}, 3);
        chk(in_ready == 1'b0, "R7 not ready", in_ready, 0);
        put(8'h01);
        chk(done == 1'b1 && error == 1'b1 && wr_valid == 1'b0, "R7 sticky",
            {done, error, wr_valid}, 6);

        // R8 end inside a message
        do_reset();
        put(8'h01);
        put(8'h00);
        end_pulse();
        chk(done == 1'b1 && error == 1'b1, "R8 truncated", {done, error}, 3);

        // R6 length below header size
        do_reset();
        seq = '{8'h01, 8'h00, 8'h02};
        put_list(seq, 3);
        chk(done == 1'b1 && error == 1'b1, "R6 short length", {done, error}, 3);

        summary();
    end
endmodule